// File: doc/BRIEF.md
# Banked Data-Memory Register File

This block is the data-memory subsystem of a small 8-bit controller core. An 8-bit address selects one of three regions. The low 32 addresses hold special registers. The next 32 hold global registers, which are the same storage in every bank. The top 192 addresses hold general RAM, and a bank-select register chooses which bank of RAM they reach. Two indirect windows read and write the location named by their own pointer registers. The window at 00h always lands in bank 0. The window at 02h follows the current bank.

The port is a single one, with a combinational read. It accepts one operation per cycle: a byte write, a single-bit set or a single-bit clear. A bit operation reads, modifies and writes the addressed location in the same cycle, and it works through the indirect windows as well. The sparse bank codes are 00h, 01h and 1Bh. Bank 1Bh implements only two small windows; the rest of it reads as zero. Special address 1Dh is a write-only register whose value is driven out to neighbouring logic. Address 1Fh returns a value supplied by that logic.

Top module: `bank_regfile`

## Requirements
- R1: On reset, every RAM byte, every global and special register, the bank select (04h), both pointers (01h, 03h) and the write-only register clear to 00h.
- R2: Addresses 20h–3Fh read and write the same 32 bytes whatever the bank select holds.
- R3: A byte written to 04h is the bank select. Codes 00h, 01h and 1Bh reach separate RAM banks at 40h–FFh, and a write in one bank leaves the other banks unchanged.
- R4: While the bank select holds any other code, RAM addresses read 00h and writes to them change nothing.
- R5: In bank 1Bh, 40h–4Eh store full bytes and C0h–E2h store only bits [3:0], with bits [7:4] reading 0. 4Fh–BFh and E3h–FFh read 00h and ignore writes.
- R6: Special addresses 0Ch, 0Fh, 13h, 17h and 18h–1Ch read 00h and ignore writes. Address 16h keeps only bits [3:0], and its bits [7:4] read 0. The other special addresses from 05h up to 1Eh, except 1Dh, are plain read/write bytes.
- R7: An access to 00h goes to the address held at 01h. When that address is 40h or above, the access lands in bank 0 whatever the bank select holds.
- R8: An access to 02h goes to the address held at 03h, in the bank the bank select names.
- R9: An indirect access whose pointer holds 00h or 02h reads 00h, and a write or bit operation through it changes nothing.
- R10: A write to 1Dh is stored and driven on `wo_q_o`, while reads of 1Dh return 00h. Reads of 1Fh return `ro_src_i`, and writes to 1Fh have no effect.
- R11: A bit set or clear changes bit `bit_sel_i` of the addressed location, directly or through a window, in one cycle. In the same cycle a byte write takes priority over a set, and a set takes priority over a clear.
- R12: Bit set and clear operations addressed to 1Dh or 1Fh change nothing.
- R13: `rdata_o` is 00h whenever `re_i` is low. When `re_i` is high, it shows the addressed location in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Direct address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Byte write enable |
| re_i | input | 1 | Read enable |
| bit_set_i | input | 1 | Set bit `bit_sel_i` of the addressed location |
| bit_clr_i | input | 1 | Clear bit `bit_sel_i` of the addressed location |
| bit_sel_i | input | 3 | Bit number for set and clear |
| ro_src_i | input | 8 | Value returned at the read-only address 1Fh |
| rdata_o | output | 8 | Read data (combinational) |
| wo_q_o | output | 8 | Contents of the write-only register at 1Dh |

## Verification
The bench builds the block with its default parameters: two full banks at codes 00h and 01h, the high bank at code 1Bh, a byte window ending at 4Eh and a nibble window spanning C0h–E2h. With these values the window edges 4Eh/4Fh and E2h/E3h are reached by single vectors, and so are an unused bank code (07h) and a bank 0 pointer used while bank 1 is selected. Self-referencing pointer values, bit operations through a window and the write-only and read-only addresses each get their own vectors. Write/set/clear priority, read-enable gating and a mid-run reset are tested directly after the table.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_WIN0   = 8'h00;
  localparam logic [AW-1:0] A_PTR0   = 8'h01;
  localparam logic [AW-1:0] A_WIN1   = 8'h02;
  localparam logic [AW-1:0] A_PTR1   = 8'h03;
  localparam logic [AW-1:0] A_BSEL   = 8'h04;
  localparam logic [AW-1:0] A_NIB    = 8'h16;
  localparam logic [AW-1:0] A_WO     = 8'h1D;
  localparam logic [AW-1:0] A_RO     = 8'h1F;
  localparam int            SPEC_LO  = 5;
  localparam int            GLOB_LO  = 32;
  localparam int            GLOB_N   = 32;
  localparam int            RAM_LO   = 64;
  localparam int            RAM_N    = 192;

  function automatic logic spec_hole(input logic [AW-1:0] a);
    return (a == 8'h0C) || (a == 8'h0F) || (a == 8'h13) || (a == 8'h17) ||
           (a >= 8'h18 && a <= 8'h1C);
  endfunction
endpackage

// File: rtl/bank_rf_resolve.sv
module bank_rf_resolve
  import bank_rf_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ptr0_i,
  input  logic [AW-1:0] ptr1_i,
  input  logic [DW-1:0] bsel_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [DW-1:0] eff_bank_o,
  output logic          null_o
);
  logic ind;

  always_comb begin
    eff_addr_o = addr_i;
    eff_bank_o = bsel_i;
    ind        = 1'b0;
    if (addr_i == A_WIN0) begin
      eff_addr_o = ptr0_i;
      eff_bank_o = '0;        // window 0 is pinned to bank 0
      ind        = 1'b1;
    end else if (addr_i == A_WIN1) begin
      eff_addr_o = ptr1_i;
      ind        = 1'b1;
    end
  end

  assign null_o = ind && (eff_addr_o == A_WIN0 || eff_addr_o == A_WIN1);
endmodule

// File: rtl/bank_rf_mem.sv
module bank_rf_mem
  import bank_rf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  parameter int BASE  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAST = BASE + DEPTH - 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    off;
  logic [IW-1:0]    idx;
  logic             hit;

  assign hit = sel_i && ({1'b0, addr_i} >= 9'(BASE)) && ({1'b0, addr_i} <= 9'(LAST));
  assign off = addr_i - AW'(BASE);
  assign idx = off[IW-1:0];
  assign rdata_o = hit ? mem[idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (hit && we_i) begin
      mem[idx] <= wdata_i;
    end
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int            NUM_FULL_BANKS = 2,
  parameter logic [DW-1:0] HI_BANK_CODE   = 8'h1B,
  parameter int            HI_BYTE_LAST   = 8'h4E,
  parameter int            HI_NIB_FIRST   = 8'hC0,
  parameter int            HI_NIB_LAST    = 8'hE2,
  parameter int            NIB_W          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic          bit_set_i,
  input  logic          bit_clr_i,
  input  logic [2:0]    bit_sel_i,
  input  logic [DW-1:0] ro_src_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] wo_q_o
);
  localparam int SPEC_N    = 32 - SPEC_LO;
  localparam int HI_BYTE_N = HI_BYTE_LAST - RAM_LO + 1;
  localparam int HI_NIB_N  = HI_NIB_LAST - HI_NIB_FIRST + 1;

  logic [AW-1:0] ptr0_q, ptr1_q;
  logic [DW-1:0] bsel_q, wo_q;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] eff_bank;
  logic          null_acc;
  logic [DW-1:0] spec_rd, glob_rd, hib_rd, loc_val, new_val, bmask;
  logic [NIB_W-1:0] hin_rd;
  logic [DW-1:0] full_rd [NUM_FULL_BANKS];
  logic [DW-1:0] ram_rd;
  logic          wr_any, spec_sel, hi_sel;

  bank_rf_resolve u_resolve (
    .addr_i     (addr_i),
    .ptr0_i     (ptr0_q),
    .ptr1_i     (ptr1_q),
    .bsel_i     (bsel_q),
    .eff_addr_o (eff_addr),
    .eff_bank_o (eff_bank),
    .null_o     (null_acc)
  );

  assign bmask  = 8'b1 << bit_sel_i;
  assign wr_any = !null_acc &&
                  (we_i || ((bit_set_i || bit_clr_i) && eff_addr != A_WO && eff_addr != A_RO));
  assign new_val = we_i      ? wdata_i :
                   bit_set_i ? (loc_val | bmask) : (loc_val & ~bmask);

  assign spec_sel = !spec_hole(eff_addr) && eff_addr != A_WO && eff_addr != A_RO;
  assign hi_sel   = (eff_bank == HI_BANK_CODE);

  bank_rf_mem #(.WIDTH(DW), .DEPTH(SPEC_N), .BASE(SPEC_LO)) u_spec (
    .clk_i, .rst_ni, .sel_i(spec_sel), .addr_i(eff_addr),
    .we_i(wr_any), .wdata_i(new_val), .rdata_o(spec_rd)
  );

  bank_rf_mem #(.WIDTH(DW), .DEPTH(GLOB_N), .BASE(GLOB_LO)) u_glob (
    .clk_i, .rst_ni, .sel_i(1'b1), .addr_i(eff_addr),
    .we_i(wr_any), .wdata_i(new_val), .rdata_o(glob_rd)
  );

  for (genvar g = 0; g < NUM_FULL_BANKS; g++) begin : g_bank
    bank_rf_mem #(.WIDTH(DW), .DEPTH(RAM_N), .BASE(RAM_LO)) u_ram (
      .clk_i, .rst_ni, .sel_i(eff_bank == DW'(g)), .addr_i(eff_addr),
      .we_i(wr_any), .wdata_i(new_val), .rdata_o(full_rd[g])
    );
  end

  bank_rf_mem #(.WIDTH(DW), .DEPTH(HI_BYTE_N), .BASE(RAM_LO)) u_hi_byte (
    .clk_i, .rst_ni, .sel_i(hi_sel), .addr_i(eff_addr),
    .we_i(wr_any), .wdata_i(new_val), .rdata_o(hib_rd)
  );

  bank_rf_mem #(.WIDTH(NIB_W), .DEPTH(HI_NIB_N), .BASE(HI_NIB_FIRST)) u_hi_nib (
    .clk_i, .rst_ni, .sel_i(hi_sel), .addr_i(eff_addr),
    .we_i(wr_any), .wdata_i(new_val[NIB_W-1:0]), .rdata_o(hin_rd)
  );

  always_comb begin
    ram_rd = hib_rd | {{(DW-NIB_W){1'b0}}, hin_rd};
    for (int b = 0; b < NUM_FULL_BANKS; b++) ram_rd = ram_rd | full_rd[b];
  end

  always_comb begin
    loc_val = '0;
    if (!null_acc) begin
      if      (eff_addr == A_PTR0) loc_val = ptr0_q;
      else if (eff_addr == A_PTR1) loc_val = ptr1_q;
      else if (eff_addr == A_BSEL) loc_val = bsel_q;
      else if (eff_addr == A_RO)   loc_val = ro_src_i;
      else begin
        loc_val = spec_rd | glob_rd | ram_rd;
        if (eff_addr == A_NIB) loc_val[DW-1:NIB_W] = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr0_q <= '0;
      ptr1_q <= '0;
      bsel_q <= '0;
      wo_q   <= '0;
    end else if (wr_any) begin
      if (eff_addr == A_PTR0) ptr0_q <= new_val;
      if (eff_addr == A_PTR1) ptr1_q <= new_val;
      if (eff_addr == A_BSEL) bsel_q <= new_val;
      if (eff_addr == A_WO)   wo_q   <= new_val;
    end
  end

  assign rdata_o = re_i ? loc_val : '0;
  assign wo_q_o  = wo_q;
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bank_rf_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          we_i,
  input logic          re_i,
  input logic          bit_set_i,
  input logic          bit_clr_i,
  input logic [DW-1:0] ro_src_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] wo_q_o,
  input logic [AW-1:0] ptr0_q,
  input logic [AW-1:0] ptr1_q,
  input logic [DW-1:0] bsel_q
);
  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && (addr_i inside {8'h0C, 8'h0F, 8'h13, 8'h17, [8'h18:8'h1C]}) |-> rdata_o == '0); // R6
  AST_NIB_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_NIB |-> rdata_o[7:4] == 4'h0); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0); // R13
  AST_WO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_WO |-> rdata_o == '0); // R10
  AST_RO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_RO |-> rdata_o == ro_src_i); // R10
  AST_WO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_WO |=> wo_q_o == $past(wdata_i)); // R10
  AST_WO_BITOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && (bit_set_i || bit_clr_i) && addr_i == A_WO |=> $stable(wo_q_o)); // R12
  AST_SELF_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && ((addr_i == A_WIN0 && (ptr0_q == A_WIN0 || ptr0_q == A_WIN1)) ||
             (addr_i == A_WIN1 && (ptr1_q == A_WIN0 || ptr1_q == A_WIN1))) |-> rdata_o == '0); // R9
  AST_BSEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_BSEL |=> bsel_q == $past(wdata_i)); // R3
  AST_PTR0_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_PTR0 |-> rdata_o == ptr0_q); // R7
endmodule

bind bank_regfile bank_regfile_chk u_chk (.*);

// File: tb/bank_regfile_test.sv
module bank_regfile_test;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OS = 2'd2, OC = 2'd3;
  localparam logic [7:0] RO_VAL = 8'h3E;

  typedef struct packed {
    logic [1:0] k;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    '{OR, 8'h40, 8'h00, 8'h00, 4'd1},  // R1 cleared RAM
    '{OW, 8'h40, 8'hA5, 8'h00, 4'd3},
    '{OR, 8'h40, 8'h00, 8'hA5, 4'd3},
    '{OW, 8'h20, 8'h3C, 8'h00, 4'd2},
    '{OW, 8'h04, 8'h01, 8'h00, 4'd3},
    '{OR, 8'h20, 8'h00, 8'h3C, 4'd2},  // R2 global seen from bank 1
    '{OR, 8'h40, 8'h00, 8'h00, 4'd3},  // R3 bank 1 separate
    '{OW, 8'h40, 8'h5A, 8'h00, 4'd3},
    '{OR, 8'h40, 8'h00, 8'h5A, 4'd3},
    '{OW, 8'h04, 8'h00, 8'h00, 4'd3},
    '{OR, 8'h40, 8'h00, 8'hA5, 4'd3},
    '{OW, 8'h04, 8'h1B, 8'h00, 4'd5},
    '{OW, 8'h4E, 8'h77, 8'h00, 4'd5},
    '{OR, 8'h4E, 8'h00, 8'h77, 4'd5},  // R5 last byte cell
    '{OW, 8'h4F, 8'h88, 8'h00, 4'd5},
    '{OR, 8'h4F, 8'h00, 8'h00, 4'd5},  // R5 hole
    '{OW, 8'hC0, 8'hFF, 8'h00, 4'd5},
    '{OR, 8'hC0, 8'h00, 8'h0F, 4'd5},  // R5 nibble
    '{OW, 8'hE2, 8'h39, 8'h00, 4'd5},
    '{OR, 8'hE2, 8'h00, 8'h09, 4'd5},
    '{OW, 8'hE3, 8'h11, 8'h00, 4'd5},
    '{OR, 8'hE3, 8'h00, 8'h00, 4'd5},
    '{OR, 8'h20, 8'h00, 8'h3C, 4'd2},
    '{OW, 8'h04, 8'h07, 8'h00, 4'd4},
    '{OW, 8'h40, 8'h99, 8'h00, 4'd4},
    '{OR, 8'h40, 8'h00, 8'h00, 4'd4},  // R4 unused code reads 0
    '{OW, 8'h04, 8'h00, 8'h00, 4'd4},
    '{OR, 8'h40, 8'h00, 8'hA5, 4'd4},  // R4 write went nowhere
    '{OW, 8'h0C, 8'hFF, 8'h00, 4'd6},
    '{OR, 8'h0C, 8'h00, 8'h00, 4'd6},
    '{OW, 8'h1A, 8'hFF, 8'h00, 4'd6},
    '{OR, 8'h1A, 8'h00, 8'h00, 4'd6},
    '{OW, 8'h16, 8'hFF, 8'h00, 4'd6},
    '{OR, 8'h16, 8'h00, 8'h0F, 4'd6},
    '{OW, 8'h04, 8'h01, 8'h00, 4'd7},
    '{OW, 8'h01, 8'h40, 8'h00, 4'd7},
    '{OR, 8'h00, 8'h00, 8'hA5, 4'd7},  // R7 bank 0 while bank 1 selected
    '{OW, 8'h00, 8'hC3, 8'h00, 4'd7},
    '{OW, 8'h03, 8'h40, 8'h00, 4'd8},
    '{OR, 8'h02, 8'h00, 8'h5A, 4'd8},  // R8 follows bank 1
    '{OW, 8'h02, 8'h6B, 8'h00, 4'd8},
    '{OR, 8'h40, 8'h00, 8'h6B, 4'd8},
    '{OW, 8'h04, 8'h00, 8'h00, 4'd8},
    '{OR, 8'h40, 8'h00, 8'hC3, 4'd7},
    '{OR, 8'h02, 8'h00, 8'hC3, 4'd8},
    '{OW, 8'h01, 8'h02, 8'h00, 4'd9},
    '{OR, 8'h00, 8'h00, 8'h00, 4'd9},  // R9 self reference
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd9},
    '{OR, 8'h02, 8'h00, 8'hC3, 4'd9},
    '{OR, 8'h01, 8'h00, 8'h02, 4'd9},
    '{OW, 8'h1D, 8'h5C, 8'h00, 4'd10},
    '{OR, 8'h1D, 8'h00, 8'h00, 4'd10}, // R10 write-only reads 0
    '{OR, 8'h1F, 8'h00, RO_VAL, 4'd10},
    '{OW, 8'h1F, 8'h00, 8'h00, 4'd10},
    '{OR, 8'h1F, 8'h00, RO_VAL, 4'd10},
    '{OS, 8'h40, 8'h02, 8'h00, 4'd11},
    '{OR, 8'h40, 8'h00, 8'hC7, 4'd11}, // R11 set bit 2
    '{OC, 8'h40, 8'h00, 8'h00, 4'd11},
    '{OR, 8'h40, 8'h00, 8'hC6, 4'd11}, // R11 clear bit 0
    '{OS, 8'h02, 8'h03, 8'h00, 4'd11},
    '{OR, 8'h40, 8'h00, 8'hCE, 4'd11}, // R11 set through window 1
    '{OS, 8'h1F, 8'h00, 8'h00, 4'd12},
    '{OR, 8'h1F, 8'h00, RO_VAL, 4'd12}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0, re = 1'b0, bset = 1'b0, bclr = 1'b0;
  logic [2:0] bsel = '0;
  logic [7:0] rdata, wo_q;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bank_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .bit_set_i(bset), .bit_clr_i(bclr), .bit_sel_i(bsel),
    .ro_src_i(RO_VAL), .rdata_o(rdata), .wo_q_o(wo_q)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic rd, input logic s, input logic c,
                       input logic [7:0] a, input logic [7:0] d, input logic [2:0] b);
    @(negedge clk);
    addr = a; wdata = d; we = w; re = rd; bset = s; bclr = c; bsel = b;
  endtask

  task automatic idle_after_edge;
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0; bset = 1'b0; bclr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input int r);
    drive(1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00, 3'd0);
    #1 check(rdata, e, r);
    idle_after_edge();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(rdata, 8'h00, 1);  // R1 idle output under reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].k == OW, VEC[i].k == OR, VEC[i].k == OS, VEC[i].k == OC,
            VEC[i].a, VEC[i].d, VEC[i].d[2:0]);
      #1;
      if (VEC[i].k == OR) check(rdata, VEC[i].e, int'(VEC[i].r));
      idle_after_edge();
    end

    // R10 write-only register visible at its output
    #1 check(wo_q, 8'h5C, 10);
    // R12 bit ops at 1Dh are ignored
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h1D, 8'h00, 3'd0); idle_after_edge();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h1D, 8'h00, 3'd2); idle_after_edge();
    check(wo_q, 8'h5C, 12);

    // R11 write beats set
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h40, 8'h11, 3'd7); idle_after_edge();
    rd_chk(8'h40, 8'h11, 11);
    // R11 set beats clear
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 8'h00, 3'd1); idle_after_edge();
    rd_chk(8'h40, 8'h13, 11);

    // R13 no read enable gives zero
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 8'h00, 3'd0);
    #1 check(rdata, 8'h00, 13);
    idle_after_edge();

    // R1 reset clears state
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(8'h40, 8'h00, 1);
    rd_chk(8'h20, 8'h00, 1);
    rd_chk(8'h04, 8'h00, 1);
    rd_chk(8'h01, 8'h00, 1);
    rd_chk(8'h05, 8'h00, 1);
    check(wo_q, 8'h00, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule